// File: doc/BRIEF.md
# Auto-Polarity Test Pulser Controller

This block is the digital controller of a hand-held pulse injector used to jog nodes on a logic board. A single pushbutton drives it. A fresh press sends one clean pulse into the node at once. Holding the button past a hold timeout switches to a steady train of pulses at a fixed repeat period, and the train stops when the button is let go. The polarity of every pulse is picked just before it starts, as the inverse of the node's sensed logic level. A node that toggles under stimulus therefore receives alternating sink and source pulses.

Between pulses the output stage is released, so the node sees high impedance. The pulse width follows a logic-family select pin: a short pulse for bipolar logic and a longer one for slow CMOS parts. After reset the indicator lamp stays on for a power-up delay. Button activity during that delay has no effect. During single-shot use the lamp flashes once per pulse, and it stays lit for the whole continuous train.

The sensed node level arrives as a plain bit with a validity flag from an external window comparator. The controller samples it only while the output is released and a settle interval has passed since the previous pulse. All timings are parameters counted in clock cycles. The repeat period must exceed the pulse width plus the settle interval.

Top module: `probe_pulser`

## Requirements
- R1: A debounced rising edge of the button, seen after the power-up delay with the pulse engine idle, starts one pulse within four clocks of the filter accepting the press.
- R2: A press released before HOLD_CYC clocks of debounced hold produces exactly one pulse.
- R3: A press held for HOLD_CYC clocks starts continuous mode, which fires one further pulse at the timeout and then one every REPEAT_CYC clocks until the debounced button falls.
- R4: The lamp is lit for FLASH_CYC clocks from each single-shot pulse and is steadily lit for the whole time continuous mode lasts; otherwise it is off.
- R5: A pulse lasts TTL_WIDTH clocks when cmos_sel is 0 and CMOS_WIDTH clocks when it is 1, with cmos_sel sampled at pulse start and drive_val constant for the whole pulse.
- R6: drive_val is 1 when node_valid is 1 and node_level is 0, is 0 when node_valid is 1 and node_level is 1, and is 1 when node_valid is 0; the node is sampled afresh at the start of each pulse.
- R7: drive_en is 0 whenever no pulse is driven, and at least SETTLE_CYC clocks with drive_en at 0 separate two pulses.
- R8: For POWERUP_CYC clocks after reset the lamp is on and no pulse is produced; a button held across the end of that delay produces no pulse until it is released and pressed again.
- R9: A button level that lasts fewer than DEBOUNCE_CYC clocks is ignored and produces no pulse.
- R10: A press accepted while a pulse or its settle interval is in progress neither shortens nor restarts that pulse and fires no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Unfiltered pushbutton, 1 = pressed |
| cmos_sel | input | 1 | Logic family: 0 short pulse, 1 long pulse |
| node_level | input | 1 | Sensed logic level of the node under test |
| node_valid | input | 1 | 1 when node_level lies outside the dead band |
| drive_en | output | 1 | Output stage enable; 0 leaves the node at high impedance |
| drive_val | output | 1 | Level driven onto the node while drive_en is 1 |
| lamp | output | 1 | Status indicator |

## Verification
The bench holds the button across the end of the power-up delay. A design that treats a level as a press would fire a stray pulse there. It flips the node after every pulse in continuous mode, so a controller that latched polarity once would send the same polarity repeatedly. It also sends a sub-threshold glitch, an invalid node level and a release-and-re-press inside a long pulse. Weak filtering would turn the glitch into a pulse, and the default polarity would be wrong for the invalid level. A careless engine would cut short or restart the long pulse, which shows up as a wrong width or an extra item on the scoreboard.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SQ_PWRUP  = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_HOLD   = 2'd2,
    SQ_REPEAT = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    PG_READY  = 2'd0,
    PG_DRIVE  = 2'd1,
    PG_SETTLE = 2'd2
  } gen_state_t;
endpackage

// File: rtl/pp_debounce.sv
module pp_debounce #(
  parameter int DEBOUNCE_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEBOUNCE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYC - 1);

  logic          sync_a, sync_b;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      run    <= '0;
      level  <= 1'b0;
    end else begin
      sync_a <= raw;
      sync_b <= sync_a;
      if (sync_b == level) begin
        run <= '0;
      end else if (run == LAST) begin
        run   <= '0;
        level <= sync_b;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

  // The filtered level only ever moves toward the synchronized input.
  p_filtered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> (level == $past(sync_b)));
endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import pp_pkg::*;
#(
  parameter int POWERUP_CYC = 50000000,
  parameter int HOLD_CYC    = 50000000,
  parameter int REPEAT_CYC  = 500000,
  parameter int FLASH_CYC   = 5000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic gen_ready,
  output logic fire,
  output logic lamp,
  output logic in_powerup
);
  localparam int PW = $clog2(POWERUP_CYC + 1);
  localparam int TW = $clog2((HOLD_CYC > REPEAT_CYC ? HOLD_CYC : REPEAT_CYC) + 1);
  localparam int FW = $clog2(FLASH_CYC + 1);
  localparam logic [PW-1:0] PW_LAST   = PW'(POWERUP_CYC - 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] REP_LAST  = TW'(REPEAT_CYC - 1);

  seq_state_t    st;
  logic          btn_q;
  logic          press;
  logic [PW-1:0] pw_cnt;
  logic [TW-1:0] tm_cnt;
  logic [FW-1:0] fl_cnt;
  logic          hold_done, rep_due;

  assign press     = btn & ~btn_q;
  assign hold_done = (st == SQ_HOLD)   && btn && (tm_cnt == HOLD_LAST);
  assign rep_due   = (st == SQ_REPEAT) && btn && (tm_cnt == REP_LAST);

  always_comb begin
    fire = 1'b0;
    if (gen_ready) begin
      fire = ((st == SQ_IDLE) && press) || hold_done || rep_due;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_PWRUP;
      btn_q  <= 1'b0;
      pw_cnt <= '0;
      tm_cnt <= '0;
      fl_cnt <= '0;
    end else begin
      btn_q <= btn;
      if (fl_cnt != '0) fl_cnt <= fl_cnt - 1'b1;
      unique case (st)
        SQ_PWRUP: begin
          if (pw_cnt == PW_LAST) st <= SQ_IDLE;
          else                   pw_cnt <= pw_cnt + 1'b1;
        end
        SQ_IDLE: begin
          if (press) begin
            st     <= SQ_HOLD;
            tm_cnt <= '0;
            if (gen_ready) fl_cnt <= FW'(FLASH_CYC);
          end
        end
        SQ_HOLD: begin
          if (!btn) begin
            st <= SQ_IDLE;
          end else if (tm_cnt == HOLD_LAST) begin
            st     <= SQ_REPEAT;
            tm_cnt <= '0;
            fl_cnt <= '0;
          end else begin
            tm_cnt <= tm_cnt + 1'b1;
          end
        end
        SQ_REPEAT: begin
          if (!btn)                  st <= SQ_IDLE;
          else if (tm_cnt == REP_LAST) tm_cnt <= '0;
          else                       tm_cnt <= tm_cnt + 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign in_powerup = (st == SQ_PWRUP);
  assign lamp = in_powerup || (st == SQ_REPEAT) || (fl_cnt != '0);

  // A train ends only once the filtered button has dropped.
  p_train_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == SQ_REPEAT) && (st != SQ_REPEAT) |-> !$past(btn));
endmodule

// File: rtl/pp_pulse_gen.sv
module pp_pulse_gen
  import pp_pkg::*;
#(
  parameter int TTL_WIDTH  = 75,
  parameter int CMOS_WIDTH = 500,
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic cmos_sel,
  input  logic node_level,
  input  logic node_valid,
  output logic ready,
  output logic drive_en,
  output logic drive_val
);
  localparam int MAXW = (TTL_WIDTH > CMOS_WIDTH) ? TTL_WIDTH : CMOS_WIDTH;
  localparam int CW   = $clog2(((MAXW > SETTLE_CYC) ? MAXW : SETTLE_CYC) + 1);
  localparam logic [CW-1:0] W_TTL  = CW'(TTL_WIDTH);
  localparam logic [CW-1:0] W_CMOS = CW'(CMOS_WIDTH);
  localparam logic [CW-1:0] S_LAST = CW'(SETTLE_CYC - 1);

  gen_state_t    st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur_w;
  logic          val_q;
  logic [CW-1:0] w_pick;

  assign w_pick = cmos_sel ? W_CMOS : W_TTL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PG_READY;
      cnt   <= '0;
      cur_w <= '0;
      val_q <= 1'b0;
    end else begin
      unique case (st)
        PG_READY: begin
          if (fire) begin
            st    <= PG_DRIVE;
            val_q <= node_valid ? ~node_level : 1'b1;
            cur_w <= w_pick;
            cnt   <= w_pick - 1'b1;
          end
        end
        PG_DRIVE: begin
          if (cnt == '0) begin
            st  <= PG_SETTLE;
            cnt <= S_LAST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PG_SETTLE: begin
          if (cnt == '0) st <= PG_READY;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= PG_READY;
      endcase
    end
  end

  assign ready     = (st == PG_READY);
  assign drive_en  = (st == PG_DRIVE);
  assign drive_val = val_q;

  // Checker: independent run-length counter for the enable.
  logic [CW-1:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               chk_len <= '0;
    else if (drive_en)        chk_len <= chk_len + 1'b1;
    else if (fire && ready)   chk_len <= '0;
  end

  p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |-> (chk_len == cur_w));
  p_polarity_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en && $past(drive_en) |-> $stable(drive_val));
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_en) |=> !drive_en);
endmodule

// File: rtl/probe_pulser.sv
module probe_pulser #(
  parameter int POWERUP_CYC  = 50000000,
  parameter int DEBOUNCE_CYC = 500000,
  parameter int HOLD_CYC     = 50000000,
  parameter int REPEAT_CYC   = 500000,
  parameter int FLASH_CYC    = 5000000,
  parameter int TTL_WIDTH    = 75,
  parameter int CMOS_WIDTH   = 500,
  parameter int SETTLE_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  input  logic cmos_sel,
  input  logic node_level,
  input  logic node_valid,
  output logic drive_en,
  output logic drive_val,
  output logic lamp
);
  logic btn_db;
  logic fire;
  logic gen_ready;
  logic in_powerup;

  pp_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_db (
    .clk(clk), .rst_n(rst_n), .raw(btn_raw), .level(btn_db)
  );

  pp_sequencer #(
    .POWERUP_CYC(POWERUP_CYC), .HOLD_CYC(HOLD_CYC),
    .REPEAT_CYC(REPEAT_CYC), .FLASH_CYC(FLASH_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .btn(btn_db), .gen_ready(gen_ready),
    .fire(fire), .lamp(lamp), .in_powerup(in_powerup)
  );

  pp_pulse_gen #(
    .TTL_WIDTH(TTL_WIDTH), .CMOS_WIDTH(CMOS_WIDTH), .SETTLE_CYC(SETTLE_CYC)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cmos_sel(cmos_sel),
    .node_level(node_level), .node_valid(node_valid), .ready(gen_ready),
    .drive_en(drive_en), .drive_val(drive_val)
  );

  p_powerup_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_powerup |-> !drive_en);
  p_powerup_lamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_powerup |-> lamp);
endmodule

// File: tb/probe_pulser_test.sv
module probe_pulser_test;
  localparam int PWR = 200, DEB = 8, HOLD = 300, REP = 100, FL = 50;
  localparam int TW = 12, CWD = 40, ST = 4;

  logic clk = 1'b0, rst_n = 1'b0, btn_raw = 1'b0, cmos_sel = 1'b0;
  logic node_level = 1'b0, node_valid = 1'b1;
  logic drive_en, drive_val, lamp;

  int vectors = 0, errs = 0, pulses = 0;
  bit toggle_node = 0;
  logic [31:0] exp_q[$];

  always #4 clk = ~clk;

  probe_pulser #(
    .POWERUP_CYC(PWR), .DEBOUNCE_CYC(DEB), .HOLD_CYC(HOLD), .REPEAT_CYC(REP),
    .FLASH_CYC(FL), .TTL_WIDTH(TW), .CMOS_WIDTH(CWD), .SETTLE_CYC(ST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .cmos_sel(cmos_sel),
    .node_level(node_level), .node_valid(node_valid),
    .drive_en(drive_en), .drive_val(drive_val), .lamp(lamp)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver side: expected pulse = {polarity, width}.
  task automatic expect_pulse(bit v, int w);
    exp_q.push_back({v, 31'(w)});
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int held);
    btn_raw = 1'b1; wait_cyc(held); btn_raw = 1'b0;
  endtask

  // Monitor: measure each pulse and compare against the queue (R5, R6, R7).
  bit in_pulse = 0, seen = 0;
  int len = 0, gap = 0;
  logic cur_val;
  always @(negedge clk) begin
    if (rst_n && drive_en) begin
      if (!in_pulse) begin
        in_pulse = 1; len = 0; cur_val = drive_val; pulses++;
        if (seen) chk("R7 gap", (gap >= ST) ? 1 : 0, 1);
      end
      len++;
    end else if (in_pulse) begin
      in_pulse = 0; seen = 1; gap = 1;
      if (exp_q.size() == 0) begin
        chk("R10 unexpected pulse", 1, 0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk("R6 polarity", int'(cur_val), int'(e[31]));
        chk("R5 width", len, int'(e[30:0]));
      end
      if (toggle_node) node_level = ~node_level;
    end else begin
      gap++;
    end
  end

  initial begin
    wait_cyc(150000);
    errs++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int base;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R8 reset lamp", int'(lamp), 1);
    chk("R7 reset drive_en", int'(drive_en), 0);

    // R8: held across the end of power-up, no pulse.
    wait_cyc(10);
    btn_raw = 1'b1;
    wait_cyc(250);
    chk("R8 lamp after delay", int'(lamp), 0);
    btn_raw = 1'b0;
    wait_cyc(30);
    chk("R8 no pulse", pulses, 0);

    // R9: short glitch.
    btn_raw = 1'b1; wait_cyc(3); btn_raw = 1'b0;
    wait_cyc(40);
    chk("R9 glitch ignored", pulses, 0);

    // R1 R2 R4 R6: single shot, low node.
    base = pulses;
    expect_pulse(1'b1, TW);
    btn_raw = 1'b1;
    wait_cyc(DEB + 7);
    chk("R1 pulse started", pulses - base, 1);
    chk("R4 flash on", int'(lamp), 1);
    wait_cyc(35);
    btn_raw = 1'b0;
    wait_cyc(80);
    chk("R4 flash off", int'(lamp), 0);
    chk("R2 one pulse", pulses - base, 1);

    // R6: high node, then invalid node.
    node_level = 1'b1;
    expect_pulse(1'b0, TW);
    press(40); wait_cyc(60);
    node_valid = 1'b0;
    expect_pulse(1'b1, TW);
    press(40); wait_cyc(60);
    node_valid = 1'b1; node_level = 1'b0;

    // R5: long width.
    cmos_sel = 1'b1;
    expect_pulse(1'b1, CWD);
    press(40); wait_cyc(80);

    // R10: release and press again inside the long pulse.
    base = pulses;
    expect_pulse(1'b1, CWD);
    press(12); wait_cyc(11); press(30);
    wait_cyc(80);
    chk("R10 single pulse", pulses - base, 1);
    cmos_sel = 1'b0;

    // R3 R4 R6: continuous train with a toggling node.
    base = pulses;
    toggle_node = 1;
    expect_pulse(1'b1, TW); expect_pulse(1'b0, TW); expect_pulse(1'b1, TW);
    expect_pulse(1'b0, TW); expect_pulse(1'b1, TW);
    btn_raw = 1'b1;
    wait_cyc(450);
    chk("R4 steady lamp", int'(lamp), 1);
    wait_cyc(210);
    btn_raw = 1'b0;
    wait_cyc(150);
    toggle_node = 0;
    chk("R3 train count", pulses - base, 5);
    chk("R4 lamp off after train", int'(lamp), 0);

    chk("R3 queue drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule